// File: doc/BRIEF.md
# Product-Term Cluster Logic Allocator

This block is a configurable sum-of-products slice. It takes 32 logic inputs and uses both the true and the complement form of each. From these literals it builds 64 programmable AND terms. The terms are grouped four at a time into 16 clusters. Each of the 16 combinational macrocell outputs is the OR of the clusters steered to it. A two-input XOR stage follows, which can invert the result or combine it with a spare product term. There are no registers on the logic path.

Configuration is written through a word-wide address/data port while `cfg_en_i` is high. The memory map is as follows:
- Addresses 0..127 hold the AND-plane connection masks. Address `2*t` is the true-literal mask of term `t`, and address `2*t+1` is its complement-literal mask.
- Addresses 128..143 hold one control word per macrocell `m`, at address `128+m`.
- Address 144 holds the per-cluster three-term mask.

Each macrocell can reach only a fixed window of neighbouring clusters, and the windows overlap. A legality checker flags two kinds of bad steering: a selection outside a window, and a cluster claimed by more than one macrocell. The hardware ignores or resolves such selections as described below.

Top module: `pterm_alloc`

## Requirements
- R1: Product term `t` is the AND of the inputs whose bit is set in its true mask and the complements of the inputs whose bit is set in its complement mask. A term with both masks zero is 0. A term that connects both the true and the complement form of one input is 0.
- R2: Cluster `c` is formed from terms `4c`..`4c+3`. Its sum is the OR of all four terms. When bit `c` of the word at address 144 is set (three-term mode), term `4c+3` is left out of the sum.
- R3: A macrocell output before the XOR stage is the OR of the clusters granted to it. Up to eight clusters, and so up to 32 terms, can be granted to one macrocell. A macrocell with no granted cluster gives 0.
- R4: The cluster window of each macrocell `m` is a fixed inclusive range:
  - m0: 0..4
  - m1: 0..5
  - m2: 0..6
  - m3: 0..7
  - m4: 0..7
  - m5: 1..8
  - m6: 2..9
  - m7: 3..10
  - m8: 5..12
  - m9: 6..13
  - m10: 7..14
  - m11: 8..15
  - m12: 8..15
  - m13: 9..15
  - m14: 10..15
  - m15: 11..15
- R5: A select bit outside the macrocell's window has no effect on any output, and it drives `conflict_o` high.
- R6: A cluster selected in-window by several macrocells is granted only to the lowest-numbered of them, and `conflict_o` goes high. Otherwise `conflict_o` is 0.
- R7: The macrocell control word has three fields:
  - bits [15:0]: the cluster select mask.
  - bits [17:16]: the XOR mode. 0 means no change, 1 means invert, 2 means XOR with term `4s+3` of source cluster `s` (this operand is 0 unless cluster `s` is in three-term mode), and 3 behaves as 0.
  - bits [21:18]: the source cluster `s`.
- R8: A configuration write takes effect at a clock edge only when both `cfg_en_i` and `cfg_we_i` are high. Writes to addresses above 144 change nothing.
- R9: While `cfg_en_i` is high, `mc_o` is all zeros.
- R10: An active-low asynchronous reset clears all configuration. After reset, `mc_o` and `conflict_o` are 0 for any input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Configuration clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_en_i | input | 1 | Configuration mode; blanks outputs |
| cfg_we_i | input | 1 | Write strobe |
| cfg_addr_i | input | 8 | Configuration word address |
| cfg_wdata_i | input | 32 | Configuration write data |
| in_i | input | 32 | Logic inputs |
| mc_o | output | 16 | Macrocell outputs |
| conflict_o | output | 1 | Illegal steering flag |

## Verification
The checker enforces the following on every cycle:
- Every grant lies inside its window.
- No cluster has more than one grant.
- Out-of-window selections raise the flag.
- Outputs are blank during configuration.
- A macrocell with no grant and no inversion stays low.
- Steering state holds when no write is strobed.

Only the bench scenarios can show the following, by comparing against a behavioural model on every clock:
- Literal polarity and contradictory terms.
- Three-term exclusion.
- The XOR operand taken from a freed term.
- Lowest-index priority when clusters are claimed twice.
- The 32-term wide function.

// File: rtl/pterm_alloc_pkg.sv
package pterm_alloc_pkg;
  localparam int N_IN       = 32;
  localparam int PT_PER_CL  = 4;
  localparam int N_CL       = 16;
  localparam int N_MC       = 16;
  localparam int N_PT       = N_CL * PT_PER_CL;
  localparam int CL_W       = $clog2(N_CL);
  localparam int MC_W       = $clog2(N_MC);
  localparam int PT_W       = $clog2(N_PT);
  localparam int ADDR_W     = 8;
  localparam int DATA_W     = N_IN;
  localparam int MC_BASE    = 2 * N_PT;
  localparam int THREE_ADDR = MC_BASE + N_MC;

  typedef enum logic [1:0] {
    XOR_NONE  = 2'd0,
    XOR_INV   = 2'd1,
    XOR_FREED = 2'd2,
    XOR_RSVD  = 2'd3
  } xor_mode_e;

  // packed MSB first: src[21:18], mode[17:16], sel[15:0]
  typedef struct packed {
    logic [CL_W-1:0] src;
    xor_mode_e       mode;
    logic [N_CL-1:0] sel;
  } mc_cfg_t;

  localparam int MC_CFG_W = $bits(mc_cfg_t);

  function automatic int win_lo(int m);
    case (m)
      0, 1, 2, 3, 4: return 0;
      5:  return 1;
      6:  return 2;
      7:  return 3;
      8:  return 5;
      9:  return 6;
      10: return 7;
      11, 12: return 8;
      13: return 9;
      14: return 10;
      default: return 11;
    endcase
  endfunction

  function automatic int win_hi(int m);
    case (m)
      0:  return 4;
      1:  return 5;
      2:  return 6;
      3, 4: return 7;
      5:  return 8;
      6:  return 9;
      7:  return 10;
      8:  return 12;
      9:  return 13;
      10: return 14;
      default: return 15;
    endcase
  endfunction

  function automatic logic [N_MC-1:0][N_CL-1:0] build_win();
    logic [N_MC-1:0][N_CL-1:0] r;
    r = '0;
    for (int m = 0; m < N_MC; m++)
      for (int c = 0; c < N_CL; c++)
        r[m][c] = (c >= win_lo(m)) && (c <= win_hi(m));
    return r;
  endfunction

  localparam logic [N_MC-1:0][N_CL-1:0] WIN = build_win();
endpackage

// File: rtl/pterm_cfg_store.sv
module pterm_cfg_store
  import pterm_alloc_pkg::*;
(
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              cfg_en_i,
  input  logic                              cfg_we_i,
  input  logic [ADDR_W-1:0]                 cfg_addr_i,
  input  logic [DATA_W-1:0]                 cfg_wdata_i,
  output logic [N_PT-1:0][N_IN-1:0]         t_mask_o,
  output logic [N_PT-1:0][N_IN-1:0]         c_mask_o,
  output mc_cfg_t [N_MC-1:0]                mc_cfg_o,
  output logic [N_CL-1:0]                   three_o
);
  logic              wr;
  logic              in_plane, in_mc, in_three;
  logic [ADDR_W-1:0] mc_off;

  assign wr       = cfg_en_i & cfg_we_i;
  assign in_plane = cfg_addr_i < ADDR_W'(MC_BASE);
  assign in_mc    = !in_plane && (cfg_addr_i < ADDR_W'(THREE_ADDR));
  assign in_three = cfg_addr_i == ADDR_W'(THREE_ADDR);
  assign mc_off   = cfg_addr_i - ADDR_W'(MC_BASE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      t_mask_o <= '0;
      c_mask_o <= '0;
      mc_cfg_o <= '0;
      three_o  <= '0;
    end else if (wr) begin
      if (in_plane) begin
        if (cfg_addr_i[0]) c_mask_o[cfg_addr_i[PT_W:1]] <= cfg_wdata_i;
        else               t_mask_o[cfg_addr_i[PT_W:1]] <= cfg_wdata_i;
      end else if (in_mc) begin
        mc_cfg_o[mc_off[MC_W-1:0]] <= mc_cfg_t'(cfg_wdata_i[MC_CFG_W-1:0]);
      end else if (in_three) begin
        three_o <= cfg_wdata_i[N_CL-1:0];
      end
    end
  end
endmodule

// File: rtl/pterm_array.sv
module pterm_array
  import pterm_alloc_pkg::*;
(
  input  logic [N_IN-1:0]           in_i,
  input  logic [N_PT-1:0][N_IN-1:0] t_mask_i,
  input  logic [N_PT-1:0][N_IN-1:0] c_mask_i,
  input  logic [N_CL-1:0]           three_i,
  output logic [N_CL-1:0]           cl_sum_o,
  output logic [N_CL-1:0]           freed_o
);
  logic [N_PT-1:0] pt;

  for (genvar t = 0; t < N_PT; t++) begin : g_pt
    logic used;
    assign used  = |(t_mask_i[t] | c_mask_i[t]);
    assign pt[t] = used & (&((~t_mask_i[t] | in_i) & (~c_mask_i[t] | ~in_i)));
  end

  for (genvar c = 0; c < N_CL; c++) begin : g_cl
    localparam int B = c * PT_PER_CL;
    logic last;
    assign last        = pt[B+PT_PER_CL-1];
    assign cl_sum_o[c] = (|pt[B +: PT_PER_CL-1]) | (last & ~three_i[c]);
    assign freed_o[c]  = last & three_i[c];
  end
endmodule

// File: rtl/pterm_steer.sv
module pterm_steer
  import pterm_alloc_pkg::*;
(
  input  mc_cfg_t [N_MC-1:0]         mc_cfg_i,
  output logic [N_MC-1:0][N_CL-1:0]  grant_o,
  output logic                       conflict_o
);
  always_comb begin
    logic [N_CL-1:0] claimed;
    logic [N_CL-1:0] legal;
    claimed    = '0;
    conflict_o = 1'b0;
    grant_o    = '0;
    for (int m = 0; m < N_MC; m++) begin
      legal = mc_cfg_i[m].sel & WIN[m];
      if (|(mc_cfg_i[m].sel & ~WIN[m])) conflict_o = 1'b1;
      if (|(legal & claimed))           conflict_o = 1'b1;
      grant_o[m] = legal & ~claimed;   // lowest index wins
      claimed    = claimed | legal;
    end
  end
endmodule

// File: rtl/pterm_mc.sv
module pterm_mc
  import pterm_alloc_pkg::*;
(
  input  logic                       cfg_en_i,
  input  logic [N_CL-1:0]            cl_sum_i,
  input  logic [N_CL-1:0]            freed_i,
  input  logic [N_MC-1:0][N_CL-1:0]  grant_i,
  input  mc_cfg_t [N_MC-1:0]         mc_cfg_i,
  output logic [N_MC-1:0]            mc_o
);
  for (genvar m = 0; m < N_MC; m++) begin : g_mc
    logic or_v, op;
    assign or_v = |(cl_sum_i & grant_i[m]);
    always_comb begin
      unique case (mc_cfg_i[m].mode)
        XOR_INV:   op = 1'b1;
        XOR_FREED: op = freed_i[mc_cfg_i[m].src];
        default:   op = 1'b0;
      endcase
    end
    assign mc_o[m] = ~cfg_en_i & (or_v ^ op);
  end
endmodule

// File: rtl/pterm_alloc.sv
module pterm_alloc
  import pterm_alloc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_en_i,
  input  logic              cfg_we_i,
  input  logic [7:0]        cfg_addr_i,
  input  logic [31:0]       cfg_wdata_i,
  input  logic [31:0]       in_i,
  output logic [15:0]       mc_o,
  output logic              conflict_o
);
  logic [N_PT-1:0][N_IN-1:0] t_mask, c_mask;
  mc_cfg_t [N_MC-1:0]        mc_cfg;
  logic [N_CL-1:0]           three, cl_sum, freed;
  logic [N_MC-1:0][N_CL-1:0] grant;

  pterm_cfg_store u_cfg (
    .clk_i, .rst_ni, .cfg_en_i, .cfg_we_i, .cfg_addr_i, .cfg_wdata_i,
    .t_mask_o(t_mask), .c_mask_o(c_mask), .mc_cfg_o(mc_cfg), .three_o(three)
  );

  pterm_array u_arr (
    .in_i, .t_mask_i(t_mask), .c_mask_i(c_mask), .three_i(three),
    .cl_sum_o(cl_sum), .freed_o(freed)
  );

  pterm_steer u_steer (
    .mc_cfg_i(mc_cfg), .grant_o(grant), .conflict_o(conflict_o)
  );

  pterm_mc u_mc (
    .cfg_en_i, .cl_sum_i(cl_sum), .freed_i(freed), .grant_i(grant),
    .mc_cfg_i(mc_cfg), .mc_o(mc_o)
  );
endmodule

// File: rtl/pterm_alloc_chk.sv
module pterm_alloc_chk
  import pterm_alloc_pkg::*;
(
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic                      cfg_en_i,
  input logic                      cfg_we_i,
  input logic [15:0]               mc_o,
  input logic                      conflict_o,
  input mc_cfg_t [N_MC-1:0]        mc_cfg,
  input logic [N_MC-1:0][N_CL-1:0] grant
);
  AST_CFG_BLANK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_en_i |-> mc_o == '0); // R9

  AST_HOLD_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cfg_en_i && cfg_we_i) |=> $stable(mc_cfg)); // R8

  for (genvar m = 0; m < N_MC; m++) begin : g_m
    AST_GRANT_IN_WIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (grant[m] & ~WIN[m]) == '0); // R4
    AST_OOW_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
      |(mc_cfg[m].sel & ~WIN[m]) |-> conflict_o); // R5
    AST_EMPTY_MC: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (grant[m] == '0 && mc_cfg[m].mode == XOR_NONE) |-> !mc_o[m]); // R3
  end

  for (genvar c = 0; c < N_CL; c++) begin : g_c
    logic [N_MC-1:0] col;
    always_comb for (int m = 0; m < N_MC; m++) col[m] = grant[m][c];
    AST_GRANT_UNIQUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $countones(col) <= 1); // R6
  end
endmodule

bind pterm_alloc pterm_alloc_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cfg_en_i(cfg_en_i), .cfg_we_i(cfg_we_i),
  .mc_o(mc_o), .conflict_o(conflict_o), .mc_cfg(mc_cfg), .grant(grant)
);

// File: tb/tb_pterm_alloc.sv
module tb_pterm_alloc;
  localparam time CLK_P = 20ns;

  logic        clk = 0, rst_n = 0;
  logic        cfg_en = 0, cfg_we = 0;
  logic [7:0]  cfg_addr = 0;
  logic [31:0] cfg_wdata = 0, in_v = 0;
  logic [15:0] mc_o;
  logic        conflict_o;

  int n_run = 0, n_fail = 0;
  string cur_req = "R10";

  always #(CLK_P/2) clk = ~clk;

  pterm_alloc dut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_en_i(cfg_en), .cfg_we_i(cfg_we),
    .cfg_addr_i(cfg_addr), .cfg_wdata_i(cfg_wdata), .in_i(in_v),
    .mc_o(mc_o), .conflict_o(conflict_o)
  );

  // behavioural model state
  logic [31:0] m_t[64], m_c[64];
  int          m_sel[16], m_mode[16], m_src[16];
  logic [15:0] m_three;
  int          lo[16] = '{0,0,0,0,0,1,2,3,5,6,7,8,8,9,10,11};
  int          hi[16] = '{4,5,6,7,7,8,9,10,12,13,14,15,15,15,15,15};

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 64; i++) begin m_t[i] = 0; m_c[i] = 0; end
      for (int i = 0; i < 16; i++) begin m_sel[i] = 0; m_mode[i] = 0; m_src[i] = 0; end
      m_three = 0;
    end else if (cfg_en && cfg_we) begin
      if (cfg_addr < 128) begin
        if (cfg_addr[0]) m_c[cfg_addr/2] = cfg_wdata; else m_t[cfg_addr/2] = cfg_wdata;
      end else if (cfg_addr < 144) begin
        m_sel[cfg_addr-128]  = cfg_wdata & 32'hFFFF;
        m_mode[cfg_addr-128] = (cfg_wdata >> 16) & 3;
        m_src[cfg_addr-128]  = (cfg_wdata >> 18) & 15;
      end else if (cfg_addr == 144) m_three = cfg_wdata[15:0];
    end
  end

  logic [15:0] e_mc;
  logic        e_conf;

  task automatic model_eval();
    bit pt[64];
    bit cs[16], fr[16];
    int owner[16];
    for (int t = 0; t < 64; t++) begin
      bit ok = (m_t[t] != 0) || (m_c[t] != 0);
      for (int i = 0; i < 32; i++) begin
        if (m_t[t][i] && !in_v[i]) ok = 0;
        if (m_c[t][i] &&  in_v[i]) ok = 0;
      end
      pt[t] = ok;
    end
    for (int c = 0; c < 16; c++) begin
      cs[c] = pt[4*c] | pt[4*c+1] | pt[4*c+2] | (pt[4*c+3] & !m_three[c]);
      fr[c] = pt[4*c+3] & m_three[c];
      owner[c] = -1;
    end
    e_conf = 0;
    for (int m = 0; m < 16; m++)
      for (int c = 0; c < 16; c++)
        if (m_sel[m][c]) begin
          if (c < lo[m] || c > hi[m]) e_conf = 1;
          else if (owner[c] >= 0) e_conf = 1;
          else owner[c] = m;
        end
    for (int m = 0; m < 16; m++) begin
      bit v = 0, op = 0;
      for (int c = 0; c < 16; c++) if (owner[c] == m && cs[c]) v = 1;
      if (m_mode[m] == 1) op = 1;
      else if (m_mode[m] == 2) op = fr[m_src[m]];
      e_mc[m] = cfg_en ? 1'b0 : (v ^ op);
    end
  endtask

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    model_eval();
    check(cur_req, "model mc_o", 32'(mc_o), 32'(e_mc));
    check(cur_req, "model conflict", 32'(conflict_o), 32'(e_conf));
  endtask

  task automatic wr(int a, logic [31:0] d);
    cfg_en = 1; cfg_we = 1; cfg_addr = 8'(a); cfg_wdata = d;
    tick();
    cfg_we = 0;
  endtask

  task automatic run(logic [31:0] v);
    cfg_en = 0; in_v = v;
    tick();
  endtask

  logic done = 0;
  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    in_v = '1;
    tick();
    check("R10", "reset mc_o", 32'(mc_o), 0);
    check("R10", "reset conflict", 32'(conflict_o), 0);

    // R1: term0 = in0 & ~in1 on m0 via c0
    cur_req = "R1";
    wr(0, 1); wr(1, 2); wr(128, 1);
    run(1);  check("R1", "in0&~in1 true", 32'(mc_o[0]), 1);
    run(3);  check("R1", "in1 kills term", 32'(mc_o[0]), 0);
    run(0);  check("R1", "in0 low", 32'(mc_o[0]), 0);
    cur_req = "R9";
    cfg_en = 1; in_v = 1; tick();
    check("R9", "blank while cfg", 32'(mc_o), 0);
    cur_req = "R1";
    wr(8, 4); wr(9, 4); wr(128, 3);
    run(4);  check("R1", "contradictory term", 32'(mc_o[0]), 0);

    // R3/R6: m3 takes c0..c7, m0 also claims c0
    cur_req = "R6";
    wr(56, 32); wr(131, 32'hFF);
    run(1);
    check("R6", "c0 stays with m0", 32'(mc_o[0]), 1);
    check("R6", "m3 lacks c0", 32'(mc_o[3]), 0);
    check("R6", "double claim flag", 32'(conflict_o), 1);
    cur_req = "R3";
    wr(128, 0);
    run(1);  check("R3", "m3 gets c0", 32'(mc_o[3]), 1);
    check("R6", "flag clear", 32'(conflict_o), 0);
    run(32); check("R3", "m3 via c7", 32'(mc_o[3]), 1);

    // R5/R4: c8 out of m0 window, in m5 window
    cur_req = "R5";
    wr(64, 64); wr(128, 32'h100);
    run(64);
    check("R5", "oow ignored", 32'(mc_o[0]), 0);
    check("R5", "oow flag", 32'(conflict_o), 1);
    cur_req = "R4";
    wr(133, 32'h100);
    run(64); check("R4", "m5 reaches c8", 32'(mc_o[5]), 1);
    wr(128, 0);

    // R2/R7: c2 term 11 on m6
    cur_req = "R2";
    wr(22, 128); wr(131, 32'h81); wr(134, 4);
    run(128); check("R2", "fourth term summed", 32'(mc_o[6]), 1);
    wr(144, 4);
    run(128); check("R2", "fourth term excluded", 32'(mc_o[6]), 0);
    cur_req = "R7";
    wr(134, (2 << 18) | (2 << 16) | 4);
    run(128); check("R7", "xor freed term", 32'(mc_o[6]), 1);
    wr(135, 1 << 16);
    run(0);  check("R7", "invert empty mc", 32'(mc_o[7]), 1);
    wr(136, 3 << 16);
    run(0);  check("R7", "mode3 as none", 32'(mc_o[8]), 0);

    // R8: no write without strobe, unmapped address
    cur_req = "R8";
    cfg_en = 1; cfg_we = 0; cfg_addr = 135; cfg_wdata = 0; tick();
    wr(200, 32'hFFFFFFFF);
    run(0); check("R8", "m7 unchanged", 32'(mc_o[7]), 1);
    check("R8", "unmapped write", 32'(mc_o & 16'hFF7F), 0);

    // randomized sweep against the model
    cur_req = "R3";
    for (int k = 0; k < 600; k++) begin
      int a = $urandom_range(0, 150);
      logic [31:0] d = $urandom;
      if (a < 128 && $urandom_range(0, 3) != 0) d = d & $urandom & $urandom;
      if (a >= 128 && a < 144 && $urandom_range(0, 1) == 0)
        d = d & 32'h003F_FFFF & ~(32'hFFFF0000 >> 16);
      wr(a, d);
      for (int j = 0; j < 3; j++) run($urandom);
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule